// File: doc/BRIEF.md
# Bit Error Tester Result Checker

This block is the receive-side checker of a field bit error test for a serial link. Parallel words arrive already deserialized, descrambled and 8b/10b-decoded, each one qualified by a valid strobe. The checker holds its own PRBS-7 generator. It seeds that generator from the incoming stream and declares lock after a run of clean words. From then on it compares every valid word with the predicted word and drives an active-low error flag. It also counts mismatched bits.

Two test modes exist, and they are mutually exclusive. In the main-link test, a latch-enable level chooses between a live flag and a sticky flag. In the sub-link test, the flag is always sticky and only a reset clears it. When neither test is requested, or when both are requested, the block sits idle and holds its flag high. The receiver is put into test mode before the far end starts sending. For that reason, whatever data arrives before lock must never raise an error.

Top module: `bert_rx_checker`

## Requirements
- R1: `mode_i` bit 0 requests the main-link test and bit 1 requests the sub-link test. The values 2'b00 and 2'b11 both mean normal operation. In normal operation, `err_n_o` is high, `locked_o` is low, and `err_bits_o` holds its value whatever data arrives.
- R2: The pattern is PRBS-7 with b[n] = b[n-6] XOR b[n-7]. Bit 0 of a word is the earliest bit in time, and bit W-1 is the latest.
- R3: The first valid word after test entry seeds the generator from its last 7 bits. A mismatch before lock reseeds the generator from the received word and restarts the run. `locked_o` rises one cycle after the 4th consecutive matching word. Before lock, no data drives `err_n_o` low or changes `err_bits_o`.
- R4: Once set, `locked_o` stays high until the decoded mode changes. Any change of decoded mode restarts seeding, and the word presented in that cycle is ignored.
- R5: A word with `rx_valid_i` low does not advance the generator and does not affect the flag or the counter.
- R6: In the main-link test with `latch_en_i`=0, each mismatching valid word after lock drives `err_n_o` low for exactly one cycle, starting the cycle after that word.
- R7: In the main-link test with `latch_en_i`=1, `err_n_o` goes low on the first mismatch after lock and stays low. Bringing `latch_en_i` to 0 clears the held error.
- R8: In the sub-link test, an error is held low regardless of `latch_en_i`. The held error survives leaving the test mode and re-entering it. Only `rst` clears it.
- R9: `err_bits_o` adds the number of mismatching bits of each locked valid word. It saturates at 65535, and it is cleared by `rst` and by entry into either test mode.
- R10: After `rst`, `err_n_o`=1, `locked_o`=0 and `err_bits_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Test request: bit 0 main-link, bit 1 sub-link |
| latch_en_i | input | 1 | Main-link sticky select; 0 clears the held error |
| rx_valid_i | input | 1 | Qualifies `rx_data_i` |
| rx_data_i | input | W (8) | Decoded received word, bit 0 earliest |
| err_n_o | output | 1 | Active-low error flag |
| locked_o | output | 1 | Checker is aligned to the pattern |
| err_bits_o | output | CNT_W (16) | Saturating mismatched-bit count |

## Verification
The bench builds the block with its default parameters: 8-bit words, a lock run of 4 words and a 16-bit counter. With 8-bit words, a single all-ones error mask adds 8 to the counter, so a few thousand corrupted words drive the 16-bit counter into saturation within the cycle budget. The short lock run lets directed tests reach the locked state in five words, so the latched, live, sub-link and re-entry scenarios can each be covered.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int PRBS_LEN = 7;

  typedef enum logic [1:0] {
    LM_OFF  = 2'd0,
    LM_MAIN = 2'd1,
    LM_SUB  = 2'd2
  } link_mode_e;

  function automatic link_mode_e decode_mode(input logic [1:0] req);
    case (req)
      2'b01:   return LM_MAIN;
      2'b10:   return LM_SUB;
      default: return LM_OFF;
    endcase
  endfunction
endpackage

// File: rtl/bert_sync.sv
module bert_sync
  import bert_pkg::*;
#(
  parameter int W          = 8,
  parameter int LOCK_WORDS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         valid,
  input  logic [W-1:0] data,
  output logic         mism_o,
  output logic [W-1:0] diff_o,
  output logic         locked_o
);
  localparam int CW = $clog2(LOCK_WORDS + 1);

  logic [PRBS_LEN-1:0] hist_q, hist_gen, hist_seed;
  logic [W-1:0]        expect_w, diff;
  logic [CW-1:0]       run_q;
  logic                seeded_q, locked_q;

  // hist[0] is the most recent bit, hist[6] the oldest
  always_comb begin
    logic [PRBS_LEN-1:0] h;
    logic                b;
    h = hist_q;
    for (int i = 0; i < W; i++) begin
      b           = h[5] ^ h[6];
      expect_w[i] = b;
      h           = {h[PRBS_LEN-2:0], b};
    end
    hist_gen = h;
    for (int j = 0; j < PRBS_LEN; j++) hist_seed[j] = data[W-1-j];
  end

  assign diff     = expect_w ^ data;
  assign mism_o   = valid && !clear && seeded_q && locked_q && (diff != '0);
  assign diff_o   = mism_o ? diff : '0;
  assign locked_o = locked_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hist_q   <= '0;
      seeded_q <= 1'b0;
      run_q    <= '0;
      locked_q <= 1'b0;
    end else if (valid) begin
      if (!seeded_q) begin
        hist_q   <= hist_seed;
        seeded_q <= 1'b1;
        run_q    <= '0;
      end else if (locked_q) begin
        hist_q <= hist_gen;
      end else if (diff == '0) begin
        hist_q <= hist_gen;
        run_q  <= run_q + 1'b1;
        if (run_q == CW'(LOCK_WORDS - 1)) locked_q <= 1'b1;
      end else begin
        hist_q <= hist_seed;
        run_q  <= '0;
      end
    end
  end

  // R4: lock holds while no restart is requested
  a_r4_lock_hold: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !clear) |=> locked_q);
  // R3: no mismatch is reported while unlocked
  a_r3_quiet_unlocked: assert property (@(posedge clk) disable iff (rst)
    !locked_o |-> !mism_o);
endmodule

// File: rtl/bert_report.sv
module bert_report
  import bert_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  link_mode_e mode,
  input  logic       latch_en,
  input  logic       mism,
  output logic       err_n_o
);
  logic main_stk_q, main_stk_d;
  logic sub_stk_q, sub_stk_d;
  logic err_n_q, err_n_d;

  always_comb begin
    main_stk_d = (mode == LM_MAIN) && latch_en && (main_stk_q || mism);
    sub_stk_d  = sub_stk_q || ((mode == LM_SUB) && mism);
    case (mode)
      LM_MAIN: err_n_d = latch_en ? !main_stk_d : !mism;
      LM_SUB:  err_n_d = !sub_stk_d;
      default: err_n_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_stk_q <= 1'b0;
      sub_stk_q  <= 1'b0;
      err_n_q    <= 1'b1;
    end else begin
      main_stk_q <= main_stk_d;
      sub_stk_q  <= sub_stk_d;
      err_n_q    <= err_n_d;
    end
  end

  assign err_n_o = err_n_q;

  // R1: idle mode forces the flag high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_OFF) |=> err_n_q);
  // R7: a held main-link error stays low while latching stays on
  a_r7_main_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_MAIN && latch_en && main_stk_q) |=> !err_n_q);
  // R8: in the sub-link test a held error keeps the flag low
  a_r8_sub_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_SUB && sub_stk_q) |=> !err_n_q);
endmodule

// File: rtl/bert_errcnt.sv
module bert_errcnt #(
  parameter int W     = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [W-1:0]     diff,
  output logic [CNT_W-1:0] count_o
);
  localparam int PW = $clog2(W + 1);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [PW-1:0]    pop;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    pop = '0;
    for (int i = 0; i < W; i++) pop = pop + PW'(diff[i]);
    sum = {1'b0, cnt_q} + (CNT_W + 1)'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (sum[CNT_W]) cnt_q <= MAXV;
    else cnt_q <= sum[CNT_W-1:0];
  end

  assign count_o = cnt_q;

  // R9: saturation holds the ceiling
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAXV && !clear) |=> cnt_q == MAXV);
  // R9: the count never decreases without a clear
  a_r9_monotonic: assert property (@(posedge clk) disable iff (rst)
    !clear |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker
  import bert_pkg::*;
#(
  parameter int W          = 8,
  parameter int LOCK_WORDS = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             latch_en_i,
  input  logic             rx_valid_i,
  input  logic [W-1:0]     rx_data_i,
  output logic             err_n_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] err_bits_o
);
  link_mode_e   mode_now, mode_prev_q;
  logic         restart, sync_clear, cnt_clear, mism;
  logic [W-1:0] diff;

  assign mode_now   = decode_mode(mode_i);
  assign restart    = (mode_now != mode_prev_q);
  assign sync_clear = restart || (mode_now == LM_OFF);
  assign cnt_clear  = restart && (mode_now != LM_OFF);

  always_ff @(posedge clk) begin
    if (rst) mode_prev_q <= LM_OFF;
    else     mode_prev_q <= mode_now;
  end

  bert_sync #(.W(W), .LOCK_WORDS(LOCK_WORDS)) u_sync (
    .clk(clk), .rst(rst), .clear(sync_clear), .valid(rx_valid_i),
    .data(rx_data_i), .mism_o(mism), .diff_o(diff), .locked_o(locked_o)
  );

  bert_report u_report (
    .clk(clk), .rst(rst), .mode(mode_now), .latch_en(latch_en_i),
    .mism(mism), .err_n_o(err_n_o)
  );

  bert_errcnt #(.W(W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(cnt_clear), .diff(diff), .count_o(err_bits_o)
  );

  // R5: an unqualified word leaves the counter alone
  a_r5_valid_gate: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid_i && !cnt_clear) |=> $stable(err_bits_o));
  // R3: in live main-link mode no error appears before lock
  a_r3_live_prelock: assert property (@(posedge clk) disable iff (rst)
    (mode_now == LM_MAIN && !latch_en_i && !locked_o) |=> err_n_o);
  // R1: idle mode keeps the checker unlocked
  a_r1_idle_unlocked: assert property (@(posedge clk) disable iff (rst)
    (mode_now == LM_OFF) |=> !locked_o);
endmodule

// File: tb/tb_bert_rx_checker.sv
module tb_bert_rx_checker;
  localparam int W = 8;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       mode_i = 2'b00;
  logic             latch_en_i = 1'b0;
  logic             rx_valid_i = 1'b0;
  logic [W-1:0]     rx_data_i = '0;
  logic             err_n_o, locked_o;
  logic [CNT_W-1:0] err_bits_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit prbs_q[$];

  always #4 clk = ~clk;

  bert_rx_checker #(.W(W), .LOCK_WORDS(4), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .latch_en_i(latch_en_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .err_n_o(err_n_o), .locked_o(locked_o), .err_bits_o(err_bits_o)
  );

  // {valid, mask[7:0], expected err_n, expected locked}; main-link live mode
  localparam logic [10:0] VEC [14] = '{
    {1'b1, 8'h00, 1'b1, 1'b0},
    {1'b1, 8'h00, 1'b1, 1'b0},
    {1'b1, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0},
    {1'b1, 8'h00, 1'b1, 1'b0},
    {1'b1, 8'h00, 1'b1, 1'b1},
    {1'b1, 8'h01, 1'b0, 1'b1},
    {1'b1, 8'h00, 1'b1, 1'b1},
    {1'b0, 8'hFF, 1'b1, 1'b1},
    {1'b1, 8'h81, 1'b0, 1'b1},
    {1'b1, 8'h00, 1'b1, 1'b1},
    {1'b1, 8'hFF, 1'b0, 1'b1},
    {1'b1, 8'hFF, 1'b0, 1'b1},
    {1'b1, 8'h00, 1'b1, 1'b1}
  };

  // R2: next word from b[n] = b[n-6] ^ b[n-7], bit 0 earliest
  function automatic logic [W-1:0] prbs_word();
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) begin
      int n = prbs_q.size();
      bit b = prbs_q[n-6] ^ prbs_q[n-7];
      prbs_q.push_back(b);
      w[i] = b;
    end
    return w;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; drives one word and returns at the next negedge
  task automatic send(input bit v, input logic [W-1:0] mask);
    rx_valid_i = v;
    rx_data_i  = v ? (prbs_word() ^ mask) : mask;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic send_raw(input logic [W-1:0] d);
    rx_valid_i = 1'b1;
    rx_data_i  = d;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic enter(input logic [1:0] m);
    mode_i = m;
    send(1'b0, '0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) prbs_q.push_back(i == 0);
    @(negedge clk);
    do_reset();
    check("R10 err_n after reset", err_n_o, 1);
    check("R10 locked after reset", locked_o, 0);
    check("R10 count after reset", err_bits_o, 0);

    // R3: garbage before the pattern starts
    enter(2'b01);
    send_raw(8'hA5); check("R3 garbage err_n", err_n_o, 1);
    send_raw(8'h3C); check("R3 garbage err_n", err_n_o, 1);
    send_raw(8'h5A); check("R3 garbage err_n", err_n_o, 1);
    check("R3 not locked on garbage", locked_o, 0);
    for (int i = 0; i < 6; i++) begin
      send(1'b1, '0);
      check("R3 err_n while aligning", err_n_o, 1);
    end
    check("R2 R3 locked on pattern", locked_o, 1);
    check("R3 no count before lock", err_bits_o, 0);

    // R6 R5 R3: table walk in main-link live mode
    enter(2'b10);
    enter(2'b01);
    check("R9 cleared on entry", err_bits_o, 0);
    for (int i = 0; i < 14; i++) begin
      send(VEC[i][10], VEC[i][9:2]);
      check($sformatf("R6 vec %0d err_n", i), err_n_o, VEC[i][1]);
      check($sformatf("R3 vec %0d locked", i), locked_o, VEC[i][0]);
    end
    check("R9 R5 bit count after table", err_bits_o, 19);

    // R7: latched main-link reporting
    latch_en_i = 1'b1;
    send(1'b1, 8'h00); check("R7 clean before error", err_n_o, 1);
    send(1'b1, 8'h10); check("R7 error latched", err_n_o, 0);
    send(1'b1, 8'h00); check("R7 held low", err_n_o, 0);
    send(1'b1, 8'h00); check("R7 held low", err_n_o, 0);
    send(1'b0, 8'h00); check("R7 held low idle", err_n_o, 0);
    latch_en_i = 1'b0;
    send(1'b1, 8'h00); check("R7 cleared by latch_en low", err_n_o, 1);
    check("R4 lock kept across latch change", locked_o, 1);
    check("R9 count 20", err_bits_o, 20);

    // R8: sub-link sticky
    enter(2'b10);
    check("R4 relock on mode change", locked_o, 0);
    check("R9 cleared on sub entry", err_bits_o, 0);
    for (int i = 0; i < 5; i++) send(1'b1, 8'h00);
    check("R3 sub locked", locked_o, 1);
    send(1'b1, 8'h04); check("R8 sub error", err_n_o, 0);
    latch_en_i = 1'b1;
    send(1'b1, 8'h00); check("R8 latch_en high no effect", err_n_o, 0);
    latch_en_i = 1'b0;
    send(1'b1, 8'h00); check("R8 latch_en low no clear", err_n_o, 0);
    enter(2'b00);
    check("R1 normal err_n high", err_n_o, 1);
    check("R1 normal unlocked", locked_o, 0);
    check("R1 count held in normal", err_bits_o, 1);
    send(1'b1, 8'hFF); check("R1 normal ignores data", err_bits_o, 1);
    enter(2'b10);
    check("R8 error survives re-entry", err_n_o, 0);
    do_reset();
    check("R8 reset clears sub error", err_n_o, 1);

    // R1: both tests requested means normal operation
    enter(2'b11);
    for (int i = 0; i < 8; i++) begin
      send(1'b1, (i % 2 == 1) ? 8'hFF : 8'h00);
      check("R1 both-mode err_n", err_n_o, 1);
    end
    check("R1 both-mode unlocked", locked_o, 0);
    check("R1 both-mode count", err_bits_o, 0);

    // R9: saturation
    enter(2'b01);
    for (int i = 0; i < 5; i++) send(1'b1, 8'h00);
    for (int i = 0; i < 8200; i++) send(1'b1, 8'hFF);
    check("R9 saturated", err_bits_o, 65535);
    check("R6 last error pulse", err_n_o, 0);
    send(1'b1, 8'h00);
    check("R6 pulse ends", err_n_o, 1);
    send(1'b1, 8'h01);
    check("R9 stays saturated", err_bits_o, 65535);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule